// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the serial front end of a small byte-addressed nonvolatile memory. When a write frame opens, it takes the start address. It then gathers each received data byte into a 16-slot page buffer. The slot pointer advances through the low address bits only, so a frame longer than a page wraps around and overwrites the slots it filled earlier. The upper address bits stay fixed for the whole frame. A valid mask records which slots were actually filled.

When chip select rises, the front end reports whether the rise came exactly on a byte boundary. If it did, and the write-enable latch is set, and the protection unit allows the target, the buffer is committed. The block scans the 16 slots in ascending order, one per clock, and issues an array write strobe for each filled slot. It then holds busy for a programmable wait, counted in system clocks. A one-cycle done pulse follows, which the surrounding logic uses to clear the write-enable latch. While busy, all frame traffic is ignored. A chip-select rise at any other point drops the frame without writing.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, busy, done and arr_we are all low.
- R2: The first byte of a frame goes to the slot given by the low 4 bits of start_addr, and each later byte goes to the next slot. Every strobe carries arr_addr = {start_addr[8:4], slot}.
- R3: After slot 15 the pointer wraps to slot 0 of the same page. A later byte replaces the one already held in that slot, and only the last value is written.
- R4: Only slots that received a byte in the current frame produce an arr_we strobe, once each. A frame that opens clears the mask.
- R5: A commit happens only on a cs_rise pulse with on_boundary high. A cs_rise with on_boundary low ends the frame with no strobes and no busy.
- R6: A commit also needs wel and region_ok both high in the cs_rise cycle. Otherwise the frame is dropped with no strobes and no busy.
- R7: busy rises in the cycle after the committing cs_rise and stays high for exactly PAGE_BYTES + WRITE_WAIT cycles. During the first PAGE_BYTES of those cycles, cycle k presents slot k, and arr_we is high in that cycle if slot k was filled.
- R8: done is a single-cycle pulse in the first cycle after busy falls, and it does not occur at any other time.
- R9: While busy, frame_start, byte_valid and cs_rise have no effect. A frame opened during busy does not exist afterwards, so a later boundary cs_rise commits nothing.
- R10: A frame that received no data bytes never commits, even with a valid boundary rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Pulse: write frame opens, start_addr valid |
| start_addr | input | ADDR_W | Start byte address of the frame |
| byte_valid | input | 1 | Pulse: byte_data holds a received data byte |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Pulse: chip select went high |
| on_boundary | input | 1 | The cs_rise came right after a byte's last bit |
| wel | input | 1 | Write-enable latch state |
| region_ok | input | 1 | Protection unit allows the target page |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Commit and self-timed write in progress |
| done | output | 1 | One-cycle pulse at write completion |

## Verification
Frames are driven with random start addresses and random lengths from zero to beyond a page. This separates in-page increments from wraparound overwrites, and separates sparse masks from full ones. The boundary flag, the latch and the protection allow are each randomly cleared. A wrongly gated commit therefore shows up either as missing busy or as stray strobes. Directed frames cover an exact wrap with overwrite, a frame with no data bytes, and a frame opened during busy followed by a boundary rise after done. The strobe order, the busy length and the done position are compared cycle by cycle against a bench model.

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int WRITE_WAIT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic              on_boundary,
  input  logic              wel,
  input  logic              region_ok,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_data,
  output logic              busy,
  output logic              done
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int CW = $clog2(WRITE_WAIT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_WAIT} st_t;

  st_t                  state_q;
  logic [7:0]           page_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;
  logic [PW-1:0]        ptr_q;
  logic [PW-1:0]        idx_q;
  logic [ADDR_W-PW-1:0] base_q;
  logic                 open_q;
  logic [CW-1:0]        cnt_q;
  logic                 done_q;

  wire idle  = (state_q == S_IDLE);
  wire take  = idle && open_q && byte_valid && !frame_start && !cs_rise;
  wire go    = idle && cs_rise && open_q && on_boundary && wel && region_ok && (|mask_q);

  assign busy     = !idle;
  assign done     = done_q;
  assign arr_we   = (state_q == S_SCAN) && mask_q[idx_q];
  assign arr_addr = {base_q, idx_q};
  assign arr_data = page_q[idx_q];

  always_ff @(posedge clk) begin
    if (take) page_q[ptr_q] <= byte_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mask_q  <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
      base_q  <= '0;
      open_q  <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (frame_start) begin
            open_q <= 1'b1;
            mask_q <= '0;
            ptr_q  <= start_addr[PW-1:0];
            base_q <= start_addr[ADDR_W-1:PW];
          end else if (cs_rise) begin
            open_q <= 1'b0;
            if (go) begin
              state_q <= S_SCAN;
              idx_q   <= '0;
            end
          end else if (take) begin
            mask_q[ptr_q] <= 1'b1;
            ptr_q         <= ptr_q + 1'b1;
          end
        end
        S_SCAN: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == PW'(PAGE_BYTES - 1)) begin
            state_q <= S_WAIT;
            cnt_q   <= CW'(WRITE_WAIT - 1);
          end
        end
        default: begin
          if (cnt_q == '0) begin
            state_q <= S_IDLE;
            mask_q  <= '0;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      endcase
    end
  end

  assert_start_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && on_boundary));
  assert_start_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel && region_ok));
  assert_scan_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SCAN && $past(state_q == S_SCAN)) |-> idx_q == $past(idx_q) + 1'b1);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(base_q));
  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !open_q);
endmodule

// File: tb/page_write_buffer_test.sv
module page_write_buffer_test;
  localparam int TW = 12;
  localparam int PB = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic [8:0] start_addr = '0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       cs_rise = 1'b0;
  logic       on_boundary = 1'b0;
  logic       wel = 1'b0;
  logic       region_ok = 1'b0;
  logic       arr_we;
  logic [8:0] arr_addr;
  logic [7:0] arr_data;
  logic       busy;
  logic       done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  page_write_buffer #(.ADDR_W(9), .PAGE_BYTES(PB), .WRITE_WAIT(TW)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
    .on_boundary(on_boundary), .wel(wel), .region_ok(region_ok),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
    .busy(busy), .done(done));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic open_frame(input logic [8:0] sa);
    @(negedge clk); frame_start = 1'b1; start_addr = sa;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); byte_valid = 1'b1; byte_data = d;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic raise_cs(input bit bnd);
    @(negedge clk); cs_rise = 1'b1; on_boundary = bnd;
    @(negedge clk); cs_rise = 1'b0; on_boundary = 1'b0;
  endtask

  function automatic bit will_commit(input bit bnd, input bit w, input bit ok, input int n);
    return bnd && w && ok && (n > 0);
  endfunction

  task automatic run_tx(input logic [8:0] sa, input int n, input bit bnd,
                        input bit w, input bit ok, input string tag);
    logic [7:0] ed [PB];
    bit em [PB];
    int p, nexp, bc, dc, dpos, werr, wn;
    bit cexp;
    for (int k = 0; k < PB; k++) begin em[k] = 1'b0; ed[k] = '0; end
    p = int'(sa[3:0]);
    open_frame(sa);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      ed[p] = d; em[p] = 1'b1;
      p = (p + 1) % PB;
      send_byte(d);
    end
    nexp = 0;
    for (int k = 0; k < PB; k++) nexp += int'(em[k]);
    cexp = will_commit(bnd, w, ok, n);
    wel = w; region_ok = ok;
    raise_cs(bnd);
    bc = 0; dc = 0; dpos = -1; werr = 0; wn = 0;
    for (int c = 0; c < PB + TW + 4; c++) begin
      if (busy) bc++;
      if (done) begin dc++; dpos = c; end
      if (arr_we) begin
        wn++;
        if (!(c < PB && em[c] && arr_addr == {sa[8:4], 4'(c)} && arr_data == ed[c])) werr++;
      end else if (cexp && c < PB && em[c]) begin
        werr++;
      end
      @(negedge clk);
    end
    if (cexp) begin
      check(bc == PB + TW, {tag, " R7 busy length"}, bc, PB + TW);
      check(werr == 0, {tag, " R2 R3 strobe address/data per slot"}, werr, 0);
      check(wn == nexp, {tag, " R4 strobe count equals filled slots"}, wn, nexp);
      check(dc == 1 && dpos == PB + TW, {tag, " R8 done position"}, dpos, PB + TW);
    end else begin
      check(bc == 0, {tag, " no busy without commit"}, bc, 0);
      check(wn == 0 && dc == 0, {tag, " no strobes without commit"}, wn + dc, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bc;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !arr_we, "R1 reset outputs low", {busy, done, arr_we}, 0);

    run_tx(9'h123, 4, 1, 1, 1, "R2 in-page increment");
    run_tx(9'h1F8, 20, 1, 1, 1, "R3 wrap and overwrite");
    run_tx(9'h040, 16, 1, 1, 1, "R3 exact full page");
    run_tx(9'h0A5, 3, 1, 1, 1, "R4 sparse mask");
    run_tx(9'h033, 5, 0, 1, 1, "R5 off-boundary abort");
    run_tx(9'h077, 5, 1, 0, 1, "R6 latch clear");
    run_tx(9'h0B0, 5, 1, 1, 0, "R6 protected");
    run_tx(9'h150, 0, 1, 1, 1, "R10 empty frame");

    for (int t = 0; t < 30; t++) begin
      run_tx(9'($urandom % 512), int'($urandom % 21), ($urandom % 4) != 0,
             ($urandom % 5) != 0, ($urandom % 5) != 0, "R5/R6 random");
    end

    // R9: traffic during busy is ignored
    open_frame(9'h010);
    send_byte(8'h5A);
    wel = 1'b1; region_ok = 1'b1;
    raise_cs(1'b1);
    open_frame(9'h020);
    send_byte(8'hC3);
    send_byte(8'h3C);
    for (int c = 0; c < PB + TW + 4 && busy; c++) @(negedge clk);
    check(!busy, "R9 first commit finished", busy, 0);
    raise_cs(1'b1);
    bc = 0;
    for (int c = 0; c < PB + 4; c++) begin
      if (busy || arr_we) bc++;
      @(negedge clk);
    end
    check(bc == 0, "R9 frame opened during busy ignored", bc, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule